// File: doc/BRIEF.md
# I2C Master Combined-Transfer Sequencer

This block is the byte-level sequencing core of an I2C master. Software loads a command word that describes up to two transactions. Each transaction has its own 8-bit byte count and its own direction. Software then pulses `go`. The block issues START and the slave address, then sends up to three internal address bytes. It then runs the data phase of each transaction and ends the sequence with a STOP, which it generates itself once the active byte counter runs out. Software never has to time the STOP.

Below this block sits a bit-level engine that performs one operation at a time: START, STOP, byte write or byte read. The block drives that engine through a one-cycle request and a one-cycle completion. Outgoing data comes from a transmit holding input, which the block acknowledges with `tx_take`. Received bytes are delivered on `rx_data`, qualified by `rx_valid`. The combined-command mode is switched on and off by separate strobes. While the mode is off, the block runs one transfer of the first count, and its direction comes from a legacy read flag.

Top module: `i2c_acmd_seq`

## Requirements
- R1: After reset, `busy`, `eng_valid`, `mode_on`, `done` and `nack_err` are all low.
- R2: `mode_on_stb` sets the combined-command mode and `mode_off_stb` clears it. When both strobes arrive in the same cycle, the mode ends up off. The state is visible on `mode_on` one cycle after the strobe.
- R3: The command word carries four fields. Bits [7:0] hold the first byte count and bit 8 holds the first direction. Bits [16:9] hold the second byte count and bit 17 holds the second direction. A direction bit of 1 means read.
- R4: Engine operation codes are 0 START, 1 STOP, 2 WRITE and 3 READ. A sequence runs in this order:
  - START;
  - the address byte {slave_addr, rw};
  - `ia_size` internal address bytes, the most significant first;
  - exactly one data operation per counted byte;
  - a STOP issued by the block itself.
- R5: While the mode is on, `legacy_rd` is ignored and each transaction's own direction bit decides between read and write.
- R6: While the mode is off, one transaction of the first count runs. Its direction comes from `legacy_rd`, and the second area is ignored.
- R7: While the mode is on and the second count is non-zero, a repeated START follows the first area. The address byte with the second direction comes next, then the second count of data bytes. A second count of zero ends the sequence after the first area.
- R8: When internal address bytes are present, the first address byte always carries rw=0. If the first area then reads, a repeated START and the address byte with rw=1 are inserted before the reads.
- R9: On reads, `eng_rd_nack` is 0 for every byte except the last byte of each read area, where it is 1.
- R10: A NACK received on any written byte (address, internal address or data) causes STOP to be the next engine request. `nack_err` is then high when `done` pulses.
- R11: A `go` with a first count of zero is ignored: `busy` stays low and no engine request appears.
- R12: `tx_take` pulses once per written data byte, in the same cycle that byte is requested. The byte sent is the value of `tx_data` in that cycle. Each read byte appears on `rx_data` with `rx_valid` one cycle after the engine completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_on_stb | input | 1 | Enable combined-command mode |
| mode_off_stb | input | 1 | Disable combined-command mode |
| go | input | 1 | Start a sequence |
| cmd_word | input | 18 | Two areas: count and direction each |
| slave_addr | input | 7 | 7-bit slave address |
| ia_size | input | 2 | Number of internal address bytes (0..3) |
| iaddr | input | 24 | Internal address value |
| legacy_rd | input | 1 | Direction used while the mode is off |
| tx_data | input | 8 | Transmit holding data |
| tx_take | output | 1 | Transmit byte consumed |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| mode_on | output | 1 | Combined-command mode state |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| nack_err | output | 1 | Last sequence ended on a NACK |
| eng_valid | output | 1 | Engine request |
| eng_op | output | 2 | Engine operation code |
| eng_wdata | output | 8 | Byte to write |
| eng_rd_nack | output | 1 | Master NACKs this read byte |
| eng_done | input | 1 | Engine operation complete |
| eng_ack_rx | input | 1 | Slave acknowledged the written byte |
| eng_rdata | input | 8 | Byte read by the engine |

## Verification
The bench targets the following corner cases:
- **Internal address followed by a read.** A block that forgets the turnaround would read with the address still in write direction, or would never send rw=1.
- **Two areas chained with opposite directions.** A wrong design drops the repeated START or reuses the first direction.
- **A second count left non-zero while the mode is off.** A wrong design runs an extra transaction.
- **The acknowledge bit on the last read byte.** A design that acknowledges the final byte would keep the slave driving the bus into the STOP.
- **NACKs injected on an address byte and on a middle data byte.** A wrong design keeps issuing bytes instead of stopping at once.
- **A zero first count.** A wrong design would start a bus sequence with no data.

// File: rtl/i2c_acmd_pkg.sv
package i2c_acmd_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } eng_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_IADR,
    ST_DATA,
    ST_STOP
  } seq_st_t;
endpackage

// File: rtl/i2c_acmd_modereg.sv
module i2c_acmd_modereg (
  input  logic clk,
  input  logic rst_n,
  input  logic on_stb,
  input  logic off_stb,
  output logic mode
);
  logic mode_q, mode_d, mode_en;

  assign mode_en = on_stb | off_stb;
  assign mode_d  = on_stb & ~off_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b0;
    else if (mode_en) mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_stb |=> !mode_q);
endmodule

// File: rtl/i2c_acmd_bytecnt.sv
module i2c_acmd_bytecnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == W'(1));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> cnt_q != '0);
endmodule

// File: rtl/i2c_acmd_fsm.sv
module i2c_acmd_fsm
  import i2c_acmd_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int IA_MAX = 3,
  parameter int IA_W   = $clog2(IA_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  mode,
  input  logic [LEN_W-1:0]      len0,
  input  logic                  dir0,
  input  logic [LEN_W-1:0]      len1,
  input  logic                  dir1,
  input  logic [6:0]            slave_addr,
  input  logic [IA_W-1:0]       ia_size,
  input  logic [8*IA_MAX-1:0]   iaddr,
  input  logic                  legacy_rd,
  input  logic [7:0]            tx_data,
  output logic                  tx_take,
  output logic                  rx_valid,
  output logic [7:0]            rx_data,
  output logic                  busy,
  output logic                  done,
  output logic                  nack_err,
  output logic                  eng_valid,
  output eng_op_t               eng_op,
  output logic [7:0]            eng_wdata,
  output logic                  eng_rd_nack,
  input  logic                  eng_done,
  input  logic                  eng_ack_rx,
  input  logic [7:0]            eng_rdata,
  output logic                  cnt_load,
  output logic [LEN_W-1:0]      cnt_val,
  output logic                  cnt_dec,
  input  logic                  cnt_last
);
  seq_st_t          st_q, st_d;
  logic             wait_q, wait_d;
  logic             area_q, area_d;
  logic             dir0_q, dir0_d, dir1_q, dir1_d;
  logic             two_q, two_d;
  logic [LEN_W-1:0] len1_q, len1_d;
  logic [IA_W-1:0]  ia_q, ia_d;
  logic             done_q, done_d, err_q, err_d;
  logic             rxv_q, rxv_d;
  logic [7:0]       rxd_q, rxd_d;
  logic             dir_cur, step, wr_phase, nack_in, cap_en;
  logic [7:0]       ia_byte;

  assign dir_cur   = area_q ? dir1_q : dir0_q;
  assign eng_valid = (st_q != ST_IDLE) && !wait_q;
  assign step      = wait_q && eng_done;
  assign wr_phase  = (st_q == ST_ADDR) || (st_q == ST_IADR) ||
                     ((st_q == ST_DATA) && !dir_cur);
  assign nack_in   = step && wr_phase && !eng_ack_rx;
  assign busy      = (st_q != ST_IDLE);
  assign tx_take   = eng_valid && (st_q == ST_DATA) && !dir_cur;
  assign eng_rd_nack = (st_q == ST_DATA) && dir_cur && cnt_last;

  always_comb begin
    ia_byte = 8'h00;
    for (int i = 0; i < IA_MAX; i++)
      if (ia_q == IA_W'(i + 1)) ia_byte = iaddr[8*i +: 8];
  end

  always_comb begin
    case (st_q)
      ST_START: eng_op = OP_START;
      ST_STOP:  eng_op = OP_STOP;
      ST_DATA:  eng_op = dir_cur ? OP_READ : OP_WRITE;
      default:  eng_op = OP_WRITE;
    endcase
    case (st_q)
      ST_ADDR: eng_wdata = {slave_addr, (ia_q != '0) ? 1'b0 : dir_cur};
      ST_IADR: eng_wdata = ia_byte;
      ST_DATA: eng_wdata = dir_cur ? 8'h00 : tx_data;
      default: eng_wdata = 8'h00;
    endcase
  end

  always_comb begin
    st_d = st_q;     wait_d = wait_q;  area_d = area_q;
    dir0_d = dir0_q; dir1_d = dir1_q;  two_d = two_q;
    len1_d = len1_q; ia_d = ia_q;      err_d = err_q;
    done_d = 1'b0;   rxv_d = 1'b0;     rxd_d = rxd_q;
    cnt_load = 1'b0; cnt_val = len0;   cnt_dec = 1'b0;
    if (eng_valid) wait_d = 1'b1;
    case (st_q)
      ST_IDLE: if (go && len0 != '0) begin
        st_d = ST_START;  wait_d = 1'b0; area_d = 1'b0;
        dir0_d = mode ? dir0 : legacy_rd;
        dir1_d = dir1;    len1_d = len1;
        two_d  = mode && (len1 != '0);
        ia_d   = ia_size; err_d = 1'b0;
        cnt_load = 1'b1;
      end
      ST_START: if (step) begin
        wait_d = 1'b0; st_d = ST_ADDR;
      end
      ST_ADDR: if (step) begin
        wait_d = 1'b0;
        if (nack_in) begin
          err_d = 1'b1; st_d = ST_STOP;
        end else st_d = (ia_q != '0) ? ST_IADR : ST_DATA;
      end
      ST_IADR: if (step) begin
        wait_d = 1'b0;
        if (nack_in) begin
          err_d = 1'b1; st_d = ST_STOP;
        end else begin
          ia_d = ia_q - 1'b1;
          if (ia_q == IA_W'(1)) st_d = dir_cur ? ST_START : ST_DATA;
        end
      end
      ST_DATA: if (step) begin
        wait_d  = 1'b0;
        cnt_dec = 1'b1;
        if (dir_cur) begin
          rxv_d = 1'b1; rxd_d = eng_rdata;
        end
        if (nack_in) begin
          err_d = 1'b1; st_d = ST_STOP;
        end else if (cnt_last) begin
          if (!area_q && two_q) begin
            area_d = 1'b1; cnt_load = 1'b1; cnt_val = len1_q;
            st_d = ST_START;
          end else st_d = ST_STOP;
        end
      end
      ST_STOP: if (step) begin
        wait_d = 1'b0; st_d = ST_IDLE; done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cap_en = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; wait_q <= 1'b0; area_q <= 1'b0;
      ia_q <= '0;      err_q <= 1'b0;  done_q <= 1'b0;
      rxv_q <= 1'b0;   rxd_q <= 8'h00;
    end else begin
      st_q <= st_d; wait_q <= wait_d; area_q <= area_d;
      ia_q <= ia_d; err_q <= err_d;   done_q <= done_d;
      rxv_q <= rxv_d;
      if (rxv_d) rxd_q <= rxd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir0_q <= 1'b0; dir1_q <= 1'b0; two_q <= 1'b0; len1_q <= '0;
    end else if (cap_en) begin
      dir0_q <= dir0_d; dir1_q <= dir1_d; two_q <= two_d; len1_q <= len1_d;
    end
  end

  assign done     = done_q;
  assign nack_err = err_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;

  // R4
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |=> !eng_valid);
  // R10
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_in |=> (eng_valid && eng_op == OP_STOP));
  // R12
  rx_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |-> $past(eng_done));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && (!go || len0 == '0)) |=> !busy);
endmodule

// File: rtl/i2c_acmd_seq.sv
module i2c_acmd_seq
  import i2c_acmd_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int IA_MAX = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           mode_on_stb,
  input  logic                           mode_off_stb,
  input  logic                           go,
  input  logic [2*LEN_W+1:0]             cmd_word,
  input  logic [6:0]                     slave_addr,
  input  logic [$clog2(IA_MAX+1)-1:0]    ia_size,
  input  logic [8*IA_MAX-1:0]            iaddr,
  input  logic                           legacy_rd,
  input  logic [7:0]                     tx_data,
  output logic                           tx_take,
  output logic                           rx_valid,
  output logic [7:0]                     rx_data,
  output logic                           mode_on,
  output logic                           busy,
  output logic                           done,
  output logic                           nack_err,
  output logic                           eng_valid,
  output logic [1:0]                     eng_op,
  output logic [7:0]                     eng_wdata,
  output logic                           eng_rd_nack,
  input  logic                           eng_done,
  input  logic                           eng_ack_rx,
  input  logic [7:0]                     eng_rdata
);
  localparam int IA_W = $clog2(IA_MAX + 1);

  logic [LEN_W-1:0] len0, len1, cnt_val;
  logic             dir0, dir1, cnt_load, cnt_dec, cnt_last;
  eng_op_t          op;

  assign len0 = cmd_word[LEN_W-1:0];
  assign dir0 = cmd_word[LEN_W];
  assign len1 = cmd_word[2*LEN_W:LEN_W+1];
  assign dir1 = cmd_word[2*LEN_W+1];

  i2c_acmd_modereg u_mode (
    .clk(clk), .rst_n(rst_n), .on_stb(mode_on_stb),
    .off_stb(mode_off_stb), .mode(mode_on)
  );

  i2c_acmd_bytecnt #(.W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .last(cnt_last)
  );

  i2c_acmd_fsm #(.LEN_W(LEN_W), .IA_MAX(IA_MAX), .IA_W(IA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .mode(mode_on),
    .len0(len0), .dir0(dir0), .len1(len1), .dir1(dir1),
    .slave_addr(slave_addr), .ia_size(ia_size), .iaddr(iaddr),
    .legacy_rd(legacy_rd), .tx_data(tx_data), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .done(done),
    .nack_err(nack_err), .eng_valid(eng_valid), .eng_op(op),
    .eng_wdata(eng_wdata), .eng_rd_nack(eng_rd_nack),
    .eng_done(eng_done), .eng_ack_rx(eng_ack_rx), .eng_rdata(eng_rdata),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_dec(cnt_dec),
    .cnt_last(cnt_last)
  );

  assign eng_op = op;
endmodule

// File: tb/i2c_acmd_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_acmd_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_on_stb, mode_off_stb, go, legacy_rd;
  logic [17:0] cmd_word;
  logic [6:0]  slave_addr;
  logic [1:0]  ia_size;
  logic [23:0] iaddr;
  logic [7:0]  tx_data, rx_data, eng_wdata, eng_rdata;
  logic tx_take, rx_valid, mode_on, busy, done, nack_err;
  logic eng_valid, eng_rd_nack, eng_done, eng_ack_rx;
  logic [1:0] eng_op;

  always #2.5 clk = ~clk;

  i2c_acmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mode_on_stb(mode_on_stb),
    .mode_off_stb(mode_off_stb), .go(go), .cmd_word(cmd_word),
    .slave_addr(slave_addr), .ia_size(ia_size), .iaddr(iaddr),
    .legacy_rd(legacy_rd), .tx_data(tx_data), .tx_take(tx_take),
    .rx_valid(rx_valid), .rx_data(rx_data), .mode_on(mode_on),
    .busy(busy), .done(done), .nack_err(nack_err),
    .eng_valid(eng_valid), .eng_op(eng_op), .eng_wdata(eng_wdata),
    .eng_rd_nack(eng_rd_nack), .eng_done(eng_done),
    .eng_ack_rx(eng_ack_rx), .eng_rdata(eng_rdata)
  );

  int nchk = 0, nerr = 0;
  string cur_req = "R4";
  logic [10:0] exp_q[$];
  logic [7:0]  rx_exp_q[$];
  int lat = 0, wr_cnt = 0, rd_idx = 0, tx_idx = 0, nack_at = 0;
  int b_wr = 0, b_tx = 0, b_rx = 0;
  bit cut = 0;
  logic [1:0] pend_op = 2'd0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Engine model, scoreboard monitor and transmit holding register
  always @(negedge clk) begin
    if (eng_done) eng_done = 1'b0;
    if (rst_n && eng_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, cur_req, "unexpected op", eng_op, 0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(eng_op == e[10:9], cur_req, "op", eng_op, e[10:9]);
        if (e[10:9] == 2'd2)
          chk(eng_wdata == e[7:0], cur_req, "wdata", eng_wdata, e[7:0]);
        if (e[10:9] == 2'd3)
          chk(eng_rd_nack == e[8], "R9", "rd_nack", eng_rd_nack, e[8]);
      end
      pend_op = eng_op;
      lat = 2;
    end else if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        eng_done = 1'b1;
        if (pend_op == 2'd2) begin
          wr_cnt++;
          eng_ack_rx = (wr_cnt != nack_at);
        end
        if (pend_op == 2'd3) begin
          eng_rdata = 8'hA0 + 8'(rd_idx);
          rd_idx++;
        end
      end
    end
    if (rst_n && rx_valid) begin
      if (rx_exp_q.size() == 0) chk(0, "R12", "unexpected rx", rx_data, 0);
      else begin
        logic [7:0] r;
        r = rx_exp_q.pop_front();
        chk(rx_data == r, "R12", "rx_data", rx_data, r);
      end
    end
    if (rst_n && tx_take) begin
      tx_idx++;
      tx_data = 8'h30 + 8'(tx_idx);
    end
  end

  task automatic push_op(input logic [1:0] op, input logic nk);
    if (!cut) exp_q.push_back({op, nk, 8'h00});
  endtask

  task automatic push_wr(input logic [7:0] b);
    if (cut) return;
    b_wr++;
    exp_q.push_back({2'd2, 1'b0, b});
    if (b_wr == nack_at) cut = 1;
  endtask

  task automatic push_data(input logic d, input int len);
    for (int k = 0; k < len; k++) begin
      if (d) begin
        if (!cut) rx_exp_q.push_back(8'hA0 + 8'(b_rx));
        b_rx++;
        push_op(2'd3, k == len - 1);
      end else begin
        push_wr(8'h30 + 8'(b_tx));
        b_tx++;
      end
    end
  endtask

  // Driver: builds the expected sequence from the requirements, then starts the DUT
  task automatic run(input string req, input logic [6:0] a, input logic [1:0] ia,
                     input logic [23:0] iad, input logic lrd,
                     input logic d0, input int l0, input logic d1, input int l1,
                     input bit two, input int nk_at, input bit exp_err);
    logic d0e;
    int t;
    cur_req = req;
    nack_at = nk_at; wr_cnt = 0; rd_idx = 0; tx_idx = 0; tx_data = 8'h30;
    b_wr = 0; b_tx = 0; b_rx = 0; cut = 0;
    d0e = mode_on ? d0 : lrd;
    push_op(2'd0, 1'b0);
    push_wr({a, (ia != 0) ? 1'b0 : d0e});
    for (int i = int'(ia); i >= 1; i--) push_wr(iad[8*(i-1) +: 8]);
    if (ia != 0 && d0e) begin
      push_op(2'd0, 1'b0);
      push_wr({a, 1'b1});
    end
    push_data(d0e, l0);
    if (two) begin
      push_op(2'd0, 1'b0);
      push_wr({a, d1});
      push_data(d1, l1);
    end
    exp_q.push_back({2'd1, 1'b0, 8'h00});
    slave_addr = a; ia_size = ia; iaddr = iad; legacy_rd = lrd;
    cmd_word = {d1, 8'(l1), d0, 8'(l0)};
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, req, "done seen", done, 1);
    chk(nack_err == exp_err, exp_err ? "R10" : req, "nack_err", nack_err, exp_err);
    @(negedge clk);
    chk(exp_q.size() == 0, req, "ops left", exp_q.size(), 0);
    chk(rx_exp_q.size() == 0, "R12", "rx left", rx_exp_q.size(), 0);
    chk(busy == 1'b0, req, "busy after done", busy, 0);
    exp_q.delete();
    rx_exp_q.delete();
  endtask

  initial begin
    #500000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_on_stb = 0; mode_off_stb = 0; go = 0;
    cmd_word = '0; slave_addr = '0; ia_size = '0; iaddr = '0; legacy_rd = 0;
    tx_data = 8'h30; eng_done = 0; eng_ack_rx = 1; eng_rdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !eng_valid && !mode_on && !done && !nack_err, "R1", "reset outputs",
        {busy, eng_valid, mode_on, done, nack_err}, 0);

    // R2 mode strobes
    mode_on_stb = 1; @(negedge clk); mode_on_stb = 0;
    chk(mode_on == 1'b1, "R2", "mode on", mode_on, 1);
    mode_on_stb = 1; mode_off_stb = 1; @(negedge clk);
    mode_on_stb = 0; mode_off_stb = 0;
    chk(mode_on == 1'b0, "R2", "both strobes", mode_on, 0);
    mode_on_stb = 1; @(negedge clk); mode_on_stb = 0;
    chk(mode_on == 1'b1, "R2", "mode on again", mode_on, 1);

    // R4, R7, R12: single write area, second count zero
    run("R4", 7'h50, 2'd0, 24'h0, 1'b0, 1'b0, 3, 1'b1, 0, 1'b0, 0, 1'b0);
    // R8, R9: two internal address bytes then read
    run("R8", 7'h51, 2'd2, 24'h123456, 1'b0, 1'b1, 4, 1'b0, 0, 1'b0, 0, 1'b0);
    // R5: legacy read flag ignored, three address bytes then write
    run("R5", 7'h2A, 2'd3, 24'hABCDEF, 1'b1, 1'b0, 2, 1'b0, 0, 1'b0, 0, 1'b0);
    // R7, R3: write area chained to read area
    run("R7", 7'h33, 2'd0, 24'h0, 1'b0, 1'b0, 2, 1'b1, 3, 1'b1, 0, 1'b0);
    // R3, R7: read area chained to write area
    run("R3", 7'h0F, 2'd1, 24'h000077, 1'b0, 1'b1, 1, 1'b0, 2, 1'b1, 0, 1'b0);
    // R10: NACK on second data byte
    run("R10", 7'h44, 2'd0, 24'h0, 1'b0, 1'b0, 5, 1'b0, 0, 1'b0, 3, 1'b1);
    // R10: NACK on address byte of a read
    run("R10", 7'h45, 2'd0, 24'h0, 1'b0, 1'b1, 3, 1'b0, 0, 1'b0, 1, 1'b1);

    // R11: zero first count ignored
    cur_req = "R11";
    cmd_word = {1'b1, 8'd3, 1'b0, 8'd0};
    go = 1'b1; @(negedge clk); go = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (busy) chk(0, "R11", "busy on zero count", busy, 0);
      @(negedge clk);
    end
    chk(!busy && !done, "R11", "stayed idle", {busy, done}, 0);

    // R6: mode off, legacy read, second area ignored
    mode_off_stb = 1; @(negedge clk); mode_off_stb = 0;
    chk(mode_on == 1'b0, "R2", "mode off", mode_on, 0);
    run("R6", 7'h60, 2'd0, 24'h0, 1'b1, 1'b0, 2, 1'b1, 5, 1'b0, 0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule